// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked on-chip requester and an external 16-bit static RAM with no clock of its own. It accepts one word-sized read or write at a time through a valid/ready handshake. It then produces the chip-select, write-strobe, output-enable, the two byte-lane selects, the address pins and the data-bus drive needed for that access. Read data returns on a separate one-cycle strobe.

Every memory timing limit is a nanosecond parameter. The controller converts each limit into whole clock cycles by rounding up, with a floor of one cycle, using a clock-period parameter. The same RTL therefore serves a fast or a slow memory grade once the parameters are set.

The controller never drives the data bus while the memory might still be driving it. It holds off the write data until the memory's outputs have had time to float. It also inserts one idle cycle when a write follows a read. A request whose lane mask is empty finishes at once, with no pin activity.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, every strobe (`mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_lo_n`, `mem_hi_n`) is high, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A write request with mask bit 0 set (low lane, data 7:0) and/or mask bit 1 set (high lane, data 15:8) stores only the selected lanes at the requested address. Lanes not selected keep their earlier contents.
- R3: A read request drives `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high. It returns the selected lanes on `rd_data`, with unselected lanes reading as zero. `rd_valid` is high for exactly one cycle.
- R4: A write holds chip select low for one address-setup cycle with the write strobe high. It then holds the write strobe low for the write-pulse count (12 cycles at defaults). The address pins stay stable and equal to the request address while chip select is low.
- R5: `mem_dq_oe` is high only while the write strobe is low. It rises the turnaround count (5 cycles at defaults) after the write strobe falls and stays high until the write ends, which covers at least the data-setup count (7 cycles).
- R6: The read strobes stay low for the access count (14 cycles at defaults). Data is captured on the clock edge that ends that window, and `rd_valid` is high in the following cycle.
- R7: `req_ready` stays low until recovery has elapsed. At defaults it is low for 14 cycles for a write and 15 cycles for a read.
- R8: A write that follows a read (ignoring empty-mask requests) first spends one extra cycle with all strobes high, so it holds `req_ready` low one cycle longer.
- R9: A request with mask 0 asserts no strobe and holds `req_ready` low for one cycle. If it is a read, it gives `rd_valid` with `rd_data` equal to zero in that cycle.
- R10: Output enable is never low while the write strobe is low. The data bus is never driven while output enable and chip select are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | 2 | Lane select, bit 0 low lane, bit 1 high lane |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lo_n | output | 1 | Low byte lane select, active low |
| mem_hi_n | output | 1 | High byte lane select, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data received from the memory |

## Verification
Every timing result is counted in cycles from the accepting clock edge. With the defaults, chip select falls in cycle 1 and the write strobe falls in cycle 2. The data drive starts in cycle 7, and a write releases ready after 14 cycles. A read gives `rd_valid` in cycle 15 and releases ready after 15 cycles. A write after a read shifts each of these by one. The bench's memory model returns a garbage word until the read strobes have been low for 14 full cycles, so a capture one cycle early shows up as a data mismatch. Outputs are sampled on falling edges, half a cycle after the registers that drive them update.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 4,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_HZOE_NS = 16,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 40,
  parameter int T_SCE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_HZWE_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TURN_C = cyc(mx(T_HZOE_NS, T_HZWE_NS));
  localparam int WE_C   = mx(mx(cyc(T_PWE_NS), TURN_C + cyc(T_SD_NS)),
                             mx(cyc(T_AW_NS) - 1, cyc(T_SCE_NS) - 1));
  localparam int REC_W  = mx(1, cyc(T_WC_NS) - 1 - WE_C);
  localparam int ACC_C  = mx(cyc(T_AA_NS), cyc(T_DOE_NS));
  localparam int REC_R  = mx(1, cyc(T_RC_NS) - ACC_C);
  localparam int MAXC   = mx(mx(WE_C, ACC_C), mx(REC_W, REC_R));
  localparam int CW     = $clog2(MAXC + 1);
  localparam int HALF   = DATA_W / 2;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_WSET, ST_WPUL, ST_RACC, ST_REC} st_t;

  st_t               st;
  logic [CW-1:0]     cnt, rec_len;
  logic              last_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q;
  logic              sel;
  logic [DATA_W-1:0] lanes;

  assign lanes     = {{(DATA_W-HALF){mask_q[1]}}, {HALF{mask_q[0]}}};
  assign sel       = (st == ST_WSET) || (st == ST_WPUL) || (st == ST_RACC);
  assign req_ready = (st == ST_IDLE);
  assign mem_cs_n  = !sel;
  assign mem_we_n  = (st != ST_WPUL);
  assign mem_oe_n  = (st != ST_RACC);
  assign mem_lo_n  = !(sel && mask_q[0]);
  assign mem_hi_n  = !(sel && mask_q[1]);
  assign mem_addr  = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe = (st == ST_WPUL) && (cnt >= CW'(TURN_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rec_len  <= CW'(1);
      last_rd  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          cnt     <= '0;
          if (req_mask == 2'b00) begin
            st       <= ST_REC;
            rec_len  <= CW'(1);
            rd_valid <= !req_write;
            rd_data  <= '0;
          end else if (req_write) begin
            last_rd <= 1'b0;
            rec_len <= CW'(REC_W);
            st      <= last_rd ? ST_GAP : ST_WSET;
          end else begin
            last_rd <= 1'b1;
            rec_len <= CW'(REC_R);
            st      <= ST_RACC;
          end
        end
        ST_GAP:  st <= ST_WSET;
        ST_WSET: st <= ST_WPUL;
        ST_WPUL: if (cnt == CW'(WE_C - 1)) begin
          cnt <= '0;
          st  <= ST_REC;
        end else cnt <= cnt + 1'b1;
        ST_RACC: if (cnt == CW'(ACC_C - 1)) begin
          cnt      <= '0;
          st       <= ST_REC;
          rd_valid <= 1'b1;
          rd_data  <= mem_dq_in & lanes;
        end else cnt <= cnt + 1'b1;
        ST_REC: if (cnt == rec_len - 1'b1) begin
          cnt <= '0;
          st  <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lo_n,
  input logic              mem_hi_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  a_r5_drive_in_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);
  a_r10_oe_off_in_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !mem_cs_n) |-> !mem_dq_oe);
  a_r7_busy_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r9_no_lane_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lo_n && mem_hi_n) |-> mem_cs_n);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_addr(mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
  localparam int TURN = 5, WEC = 12, ACC = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rd_valid;
  logic [17:0] req_addr, mem_addr, cur_addr;
  logic [15:0] req_wdata, rd_data, mem_dq_out, mem_dq_in;
  logic [1:0] req_mask;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dq_oe;

  sram_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int nchk = 0, nfail = 0;
  logic [15:0] mdl [0:63];
  logic [15:0] refm [0:63];
  int rd_low = 0;
  logic last_rd = 1'b0;
  logic mon_on = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial for (int i = 0; i < 64; i++) mdl[i] = 16'h0;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_low <= rd_low + 1;
    else rd_low <= 0;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lo_n) mdl[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_hi_n) mdl[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
    if (mon_on) begin
      if (!mem_cs_n && !mem_oe_n && mem_dq_oe) chk("R10 bus contention", 1, 0);
      if (!mem_we_n && !mem_oe_n) chk("R10 oe low during we", 1, 0);
      if (!mem_cs_n && mem_addr != cur_addr) chk("R4 address pins", int'(mem_addr), int'(cur_addr));
    end
  end

  always_comb begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (rd_low >= ACC)
        mem_dq_in = {mem_hi_n ? 8'hA5 : mdl[mem_addr[5:0]][15:8],
                     mem_lo_n ? 8'h5A : mdl[mem_addr[5:0]][7:0]};
      else mem_dq_in = 16'hBAD0;
    end else mem_dq_in = 16'hFFFF;
  end

  task automatic run(input logic w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int n, we_cnt, we_first, dq_first, dq_cnt, cs_cnt, cs_first, oel, rv_at, rv_n, any, lane_bad;
    logic [15:0] rv_d, lanes;
    int gap;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; we_cnt = 0; we_first = -1; dq_first = -1; dq_cnt = 0; cs_cnt = 0;
    cs_first = -1; oel = 0; rv_at = -1; rv_n = 0; any = 0; lane_bad = 0; rv_d = 16'h0;
    while (!req_ready && n < 100) begin
      n++;
      if (!mem_cs_n) begin
        cs_cnt++; if (cs_first < 0) cs_first = n;
        if (mem_lo_n != !m[0] || mem_hi_n != !m[1]) lane_bad++;
      end
      if (!mem_we_n) begin we_cnt++; if (we_first < 0) we_first = n; end
      if (mem_dq_oe) begin dq_cnt++; if (dq_first < 0) dq_first = n; end
      if (!mem_oe_n) oel++;
      if (!mem_cs_n || !mem_we_n || !mem_oe_n || !mem_lo_n || !mem_hi_n) any = 1;
      if (rd_valid) begin rv_n++; rv_at = n; rv_d = rd_data; end
      @(negedge clk);
    end
    lanes = {{8{m[1]}}, {8{m[0]}}};
    gap = (w && m != 2'b00 && last_rd) ? 1 : 0;
    if (m == 2'b00) begin
      chk("R9 empty busy", n, 1);
      chk("R9 empty no strobe", any, 0);
      if (!w) begin
        chk("R9 empty rd_valid cycle", rv_at, 1);
        chk("R9 empty rd_data", int'(rv_d), 0);
      end
    end else if (w) begin
      chk(gap ? "R8 write busy after read" : "R7 write busy", n, 14 + gap);
      chk(gap ? "R8 cs delayed by gap" : "R4 cs first", cs_first, 1 + gap);
      chk("R4 cs low cycles", cs_cnt, WEC + 1);
      chk("R4 we first", we_first, 2 + gap);
      chk("R4 we low cycles", we_cnt, WEC);
      chk("R5 drive start", dq_first, we_first + TURN);
      chk("R5 drive cycles", dq_cnt, WEC - TURN);
      chk("R2 oe held high", oel, 0);
      chk("R2 lane selects", lane_bad, 0);
      refm[a[5:0]] = (refm[a[5:0]] & ~lanes) | (d & lanes);
      last_rd = 1'b0;
    end else begin
      chk("R7 read busy", n, 15);
      chk("R6 oe low cycles", oel, ACC);
      chk("R3 cs low cycles", cs_cnt, ACC);
      chk("R3 we held high", we_cnt, 0);
      chk("R6 rd_valid cycle", rv_at, ACC + 1);
      chk("R3 rd_valid one pulse", rv_n, 1);
      chk("R3 read data", int'(rv_d), int'(refm[a[5:0]] & lanes));
      chk("R3 lane selects", lane_bad, 0);
      last_rd = 1'b1;
    end
  endtask

  function automatic logic [17:0] addr_of(input int i);
    case (i)
      0: return 18'h00000;  1: return 18'h3FFFF;
      2: return 18'h2AAAA;  3: return 18'h15555;
      4: return 18'h00101;  5: return 18'h3C0C2;
      6: return 18'h12343;  default: return 18'h20004;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refm[i] = 16'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_mask = '0; cur_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n}, 5'b11111);
    chk("R1 drive off in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n}, 5'b11111);
    chk("R1 drive off after reset", mem_dq_oe, 0);
    chk("R1 ready after reset", req_ready, 1);
    mon_on = 1'b1;
    for (int i = 0; i < 8; i++) run(1'b1, addr_of(i), 16'h1F2E ^ 16'(i * 16'h0707), 2'b11);
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [17:0] a;
        a = addr_of(i);
        run(1'b1, a, a[15:0] ^ 16'(m * 16'h1111) ^ 16'hC35A, 2'(m));
        for (int r = 0; r < 4; r++) run(1'b0, a, 16'h0, 2'(r));
      end
    end
    run(1'b0, addr_of(2), 16'h0, 2'b11);
    run(1'b0, addr_of(3), 16'h0, 2'b00);
    run(1'b1, addr_of(3), 16'hBEEF, 2'b11);
    run(1'b0, addr_of(3), 16'h0, 2'b11);
    mon_on = 1'b0;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule